// File: doc/BRIEF.md
# Banked Scratchpad with Bank-Conflict Serialization

This block is a word-interleaved scratchpad that serves one warp-wide request at a time. A request carries up to 32 lane addresses (word-granular), a per-lane enable mask, one read/write flag for the whole request and per-lane write data. Every word address selects a bank from its five low bits and a row inside that bank from the remaining high bits. Each bank performs one access per cycle, independently of the other banks.

After it accepts a request, the block drops `ready` and works through the enabled lanes one pass per cycle. In every pass, each bank serves the lowest-numbered lane still waiting on it, together with every other waiting lane that addresses the same word. Reads of a shared word are therefore broadcast, and writes to a shared word collapse into one store. The request needs as many passes as the most heavily loaded bank has distinct words. When the last pass completes, `done` pulses for one cycle, `ready` returns high, and `rd_data` holds the per-lane read results.

Top module: `bsm_conflict_serializer`

## Requirements
- R1: The bank of a word is address bits [4:0] and the row is bits [9:5]. An accepted request raises `done` exactly K rising edges after the accepting edge, where K is the largest number of distinct words that the enabled lanes place in any single bank.
- R2: 32 lanes reading words at a stride of 2 take exactly 2 passes.
- R3: 32 lanes at a stride of 1 or at an odd stride such as 3 take exactly 1 pass.
- R4: Lanes reading the same word cost one access. All 32 lanes reading one word finish in 1 pass, and each of them receives that word.
- R5: 32 lanes addressing 32 distinct words of a single bank take exactly 32 passes, and no request keeps `ready` low for more than 32 cycles.
- R6: When a read completes, lane i of `rd_data` (bits [32i+31:32i]) holds the word at that lane's address. Disabled lanes read zero.
- R7: A write stores each enabled lane's data at its address. When several lanes write one word, the highest-numbered lane's data remains. After a write request, `rd_data` is all zero.
- R8: `ready` is high while idle and low from the accepting edge until `done` rises. `done` lasts exactly one cycle, and `ready` is high in that cycle.
- R9: `req_valid` while `ready` is low is ignored: it neither changes memory nor alters the timing or results of the request in progress.
- R10: After reset, `ready` is 1, `done` is 0 and `rd_data` is zero.
- R11: A request with no enabled lanes completes with `done` one edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken on an edge where `ready` is high |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_lane_en | input | 32 | Per-lane enable |
| req_addr | input | 320 | Lane i word address in bits [10i+9:10i] |
| req_wdata | input | 1024 | Lane i write data in bits [32i+31:32i] |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle pulse when a request finishes |
| rd_data | output | 1024 | Lane i read result in bits [32i+31:32i] |

## Verification
The block is driven with unit stride, stride 2, stride 3, stride 16, a single shared word, 32 words in one bank and stride 64, where pairs of lanes share a word inside a single bank. Measuring the pass count for each pattern separates correct bank decoding and correct merging from the two failure modes: over-serialization of broadcast reads and missed conflicts. Read-back after writes with a shared word, partial masks, an empty mask and a request offered while the block is busy shows which lane wins a write, that disabled lanes return zero and that a request offered while busy is dropped.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SERVE = 1'b1
  } bsm_state_e;
endpackage

// File: rtl/bsm_prio_pick.sv
// Priority picker: index of the lowest (or highest) set request bit.
module bsm_prio_pick #(
  parameter int N          = 32,
  parameter bit HIGH_FIRST = 1'b0,
  localparam int IDX_W     = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  generate
    if (HIGH_FIRST) begin : g_high
      always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
          if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
          end
        end
      end
    end else begin : g_low
      always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
          if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bsm_bank.sv
// One scratchpad bank: one synchronous write port, combinational read.
module bsm_bank #(
  parameter int WORDS  = 32,
  parameter int DATA_W = 32,
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/bsm_bank_slice.sv
// Per-bank arbitration: picks the leading lane, gathers every lane that
// targets the same row, and selects the highest such lane as the writer.
module bsm_bank_slice #(
  parameter int LANES  = 32,
  parameter int ROW_W  = 5,
  parameter int DATA_W = 32,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                              clk,
  input  logic                              serve_en,
  input  logic                              write_mode,
  input  logic [LANES-1:0]                  want,
  input  logic [LANES-1:0][ROW_W-1:0]       lane_row,
  input  logic [LANES-1:0][DATA_W-1:0]      lane_wdata,
  output logic [LANES-1:0]                  group,
  output logic [DATA_W-1:0]                 rdata
);
  logic              lead_found;
  logic [LIDX_W-1:0] lead_idx;
  logic              wr_found;
  logic [LIDX_W-1:0] wr_idx;
  logic [ROW_W-1:0]  lead_row;
  logic              bank_we;

  bsm_prio_pick #(.N(LANES), .HIGH_FIRST(1'b0)) lead_pick_i (
    .req   (want),
    .found (lead_found),
    .idx   (lead_idx)
  );

  assign lead_row = lane_row[lead_idx];

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      group[l] = want[l] && lead_found && (lane_row[l] == lead_row);
    end
  end

  bsm_prio_pick #(.N(LANES), .HIGH_FIRST(1'b1)) wr_pick_i (
    .req   (group),
    .found (wr_found),
    .idx   (wr_idx)
  );

  assign bank_we = serve_en && write_mode && wr_found;

  bsm_bank #(.WORDS(1 << ROW_W), .DATA_W(DATA_W)) bank_i (
    .clk   (clk),
    .we    (bank_we),
    .addr  (lead_row),
    .wdata (lane_wdata[wr_idx]),
    .rdata (rdata)
  );
endmodule

// File: rtl/bsm_conflict_serializer.sv
module bsm_conflict_serializer #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int WORDS  = 1024,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [LANES-1:0]          req_lane_en,
  input  logic [LANES*ADDR_W-1:0]   req_addr,
  input  logic [LANES*DATA_W-1:0]   req_wdata,
  output logic                      ready,
  output logic                      done,
  output logic [LANES*DATA_W-1:0]   rd_data
);
  import bsm_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // request state
  bsm_state_e                      state_q, state_d;
  logic [LANES-1:0]                pend_q, pend_d;
  logic [LANES-1:0][DATA_W-1:0]    rdata_q, rdata_d;
  logic                            done_q, done_d;
  logic [LANES-1:0][ADDR_W-1:0]    addr_q;
  logic [LANES-1:0][DATA_W-1:0]    wdata_q;
  logic                            write_q;
  logic                            load_en;
  logic                            serve_en;

  // per-bank / per-lane wiring
  logic [BANKS-1:0][LANES-1:0]     want_b;
  logic [BANKS-1:0][LANES-1:0]     group_b;
  logic [BANKS-1:0][DATA_W-1:0]    bank_rdata;
  logic [LANES-1:0][ROW_W-1:0]     lane_row;
  logic [LANES-1:0][DATA_W-1:0]    lane_rdata;
  logic [LANES-1:0]                served;

  assign ready    = (state_q == ST_IDLE);
  assign done     = done_q;
  assign rd_data  = rdata_q;
  assign serve_en = (state_q == ST_SERVE);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_row[l]   = addr_q[l][ADDR_W-1:BANK_W];
      lane_rdata[l] = bank_rdata[addr_q[l][BANK_W-1:0]];
    end
  end

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      always_comb begin
        for (int l = 0; l < LANES; l++) begin
          want_b[b][l] = pend_q[l] && (addr_q[l][BANK_W-1:0] == BANK_W'(b));
        end
      end

      bsm_bank_slice #(.LANES(LANES), .ROW_W(ROW_W), .DATA_W(DATA_W)) slice_i (
        .clk        (clk),
        .serve_en   (serve_en),
        .write_mode (write_q),
        .want       (want_b[b]),
        .lane_row   (lane_row),
        .lane_wdata (wdata_q),
        .group      (group_b[b]),
        .rdata      (bank_rdata[b])
      );
    end
  endgenerate

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) begin
      served = served | group_b[b];
    end
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    load_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load_en = 1'b1;
          pend_d  = req_lane_en;
          rdata_d = '0;
          state_d = ST_SERVE;
        end
      end
      ST_SERVE: begin
        pend_d = pend_q & ~served;
        for (int l = 0; l < LANES; l++) begin
          if (served[l] && !write_q) rdata_d[l] = lane_rdata[l];
        end
        if (pend_d == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
    end
  end

  // request capture registers, enabled on accept
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      write_q <= 1'b0;
    end else if (load_en) begin
      write_q <= req_write;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end
endmodule

// File: rtl/bsm_conflict_serializer_chk.sv
module bsm_conflict_serializer_chk #(
  parameter int LANES = 32,
  localparam int CNT_W = $clog2(LANES) + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             ready,
  input logic             done,
  input logic             write_q,
  input logic [LANES-1:0] pend_q
);
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (ready)  busy_cnt <= '0;
    else             busy_cnt <= busy_cnt + 1'b1;
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> (!ready && !done));

  assert_pass_progress_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && pend_q != '0) |=>
      (($countones(pend_q) < $countones($past(pend_q))) &&
       ((pend_q & ~$past(pend_q)) == '0)));

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CNT_W'(LANES));

  assert_busy_ignores_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(write_q));
endmodule

bind bsm_conflict_serializer bsm_conflict_serializer_chk #(.LANES(LANES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .ready     (ready),
  .done      (done),
  .write_q   (write_q),
  .pend_q    (pend_q)
);

// File: tb/bsm_conflict_serializer_tb_top.sv
`timescale 1ns/1ps
module bsm_conflict_serializer_tb_top;
  localparam int LN = 32;
  localparam int AW = 10;
  localparam int DW = 32;

  typedef struct packed {
    logic        wr;
    logic [9:0]  base;
    logic [10:0] stride;
    logic [31:0] mask;
    logic [5:0]  cyc;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'd0,   11'd1,  32'hFFFF_FFFF, 6'd1,  4'd3},  // R3 unit stride, R6 data
    '{1'b0, 10'd0,   11'd2,  32'hFFFF_FFFF, 6'd2,  4'd2},  // R2 stride 2
    '{1'b0, 10'd1,   11'd3,  32'hFFFF_FFFF, 6'd1,  4'd3},  // R3 odd stride
    '{1'b0, 10'd5,   11'd0,  32'hFFFF_FFFF, 6'd1,  4'd4},  // R4 broadcast
    '{1'b1, 10'd100, 11'd32, 32'hFFFF_FFFF, 6'd32, 4'd5},  // R5 one bank, writes
    '{1'b0, 10'd100, 11'd32, 32'hFFFF_FFFF, 6'd32, 4'd5},  // R5 one bank, reads
    '{1'b0, 10'd32,  11'd1,  32'h0000_F0F0, 6'd1,  4'd6},  // R6 disabled lanes zero
    '{1'b1, 10'd200, 11'd0,  32'hFFFF_FFFF, 6'd1,  4'd7},  // R7 all write one word
    '{1'b0, 10'd200, 11'd0,  32'h0000_0001, 6'd1,  4'd7},  // R7 read back winner
    '{1'b1, 10'd0,   11'd1,  32'h0000_0000, 6'd1,  4'd11}, // R11 empty request
    '{1'b0, 10'd0,   11'd16, 32'hFFFF_FFFF, 6'd16, 4'd1},  // R1 two banks, 16 deep
    '{1'b0, 10'd8,   11'd64, 32'hFFFF_FFFF, 6'd16, 4'd4},  // R4 merged pairs in one bank
    '{1'b1, 10'd8,   11'd64, 32'hFFFF_FFFF, 6'd16, 4'd7},  // R7 paired writes
    '{1'b0, 10'd8,   11'd64, 32'hFFFF_FFFF, 6'd16, 4'd7}   // R7 higher lane kept
  };

  logic               clk;
  logic               rst_n;
  logic               req_valid;
  logic               req_write;
  logic [LN-1:0]      req_lane_en;
  logic [LN*AW-1:0]   req_addr;
  logic [LN*DW-1:0]   req_wdata;
  logic               ready;
  logic               done;
  logic [LN*DW-1:0]   rd_data;

  int n_checks;
  int n_bad;
  bit finished;

  logic [AW-1:0] t_addr [LN];
  logic [DW-1:0] t_wd   [LN];
  logic [DW-1:0] ref_mem [1024];

  bsm_conflict_serializer dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_lane_en (req_lane_en),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .ready       (ready),
    .done        (done),
    .rd_data     (rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  endtask

  task automatic run_req(input logic wr, input logic [31:0] mask, input int exp_cyc,
                         input string rq, input bit intrude);
    int cyc;
    bit seen;
    bit rdy_bad;
    logic [LN*DW-1:0] exp_rd;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid   = 1'b1;
    req_write   = wr;
    req_lane_en = mask;
    for (int l = 0; l < LN; l++) begin
      req_addr[l*AW +: AW]  = t_addr[l];
      req_wdata[l*DW +: DW] = t_wd[l];
    end
    @(posedge clk);
    @(negedge clk);
    if (intrude) begin
      // R9: a write to word 0 offered while busy must be dropped
      req_write   = 1'b1;
      req_lane_en = '1;
      for (int l = 0; l < LN; l++) begin
        req_addr[l*AW +: AW]  = '0;
        req_wdata[l*DW +: DW] = 32'hDEAD_BEEF;
      end
    end else begin
      req_valid = 1'b0;
    end
    cyc = 0;
    seen = 1'b0;
    rdy_bad = 1'b0;
    for (int k = 0; k < 80 && !seen; k++) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        req_valid = 1'b0;
      end else if (ready) begin
        rdy_bad = 1'b1;
      end
    end
    req_valid = 1'b0;
    check(seen && cyc == exp_cyc, rq, 64'(cyc), 64'(exp_cyc), "pass count");
    check(!rdy_bad, "R8", 64'(rdy_bad), 64'd0, "ready low while busy");
    check(ready === 1'b1, "R8", 64'(ready), 64'd1, "ready with done");
    exp_rd = '0;
    for (int l = 0; l < LN; l++) begin
      if (!wr && mask[l]) exp_rd[l*DW +: DW] = ref_mem[t_addr[l]];
    end
    n_checks++;
    if (rd_data !== exp_rd) begin
      n_bad++;
      for (int l = 0; l < LN; l++) begin
        if (rd_data[l*DW +: DW] !== exp_rd[l*DW +: DW])
          $display("FAIL %s R6 lane %0d data: actual=%0h expected=%0h", rq, l,
                   rd_data[l*DW +: DW], exp_rd[l*DW +: DW]);
      end
    end
    if (wr) begin
      for (int l = 0; l < LN; l++) begin
        if (mask[l]) ref_mem[t_addr[l]] = t_wd[l];
      end
    end
    @(negedge clk);
    check(done === 1'b0, "R8", 64'(done), 64'd0, "done one cycle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    n_checks = 0;
    n_bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_lane_en = '0;
    req_addr = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(ready === 1'b1, "R10", 64'(ready), 64'd1, "ready in reset");
    check(done === 1'b0, "R10", 64'(done), 64'd0, "done in reset");
    check(rd_data === '0, "R10", 64'(rd_data[63:0]), 64'd0, "rd_data in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ready === 1'b1 && done === 1'b0, "R10", {62'd0, ready, done}, 64'd2,
          "state after release");

    // fill all 1024 words, 32 per request at unit stride (R1, R3)
    for (int blk = 0; blk < 32; blk++) begin
      for (int l = 0; l < LN; l++) begin
        t_addr[l] = AW'(blk * 32 + l);
        t_wd[l]   = 32'h1234_0000 + 32'(blk * 97 + l * 7);
      end
      run_req(1'b1, 32'hFFFF_FFFF, 1, "R1", 1'b0);
    end

    // table of patterns
    for (int v = 0; v < NV; v++) begin
      for (int l = 0; l < LN; l++) begin
        t_addr[l] = AW'(int'(VECS[v].base) + l * int'(VECS[v].stride));
        t_wd[l]   = (32'(v) << 24) | (32'(l) << 16) | 32'(t_addr[l]);
      end
      run_req(VECS[v].wr, VECS[v].mask, int'(VECS[v].cyc),
              $sformatf("R%0d", VECS[v].rq), 1'b0);
    end

    // R9: offer a write while a 32-pass read is in flight
    for (int l = 0; l < LN; l++) begin
      t_addr[l] = AW'(100 + l * 32);
      t_wd[l]   = '0;
    end
    run_req(1'b0, 32'hFFFF_FFFF, 32, "R9", 1'b1);
    for (int l = 0; l < LN; l++) begin
      t_addr[l] = '0;
      t_wd[l]   = '0;
    end
    run_req(1'b0, 32'h0000_0001, 1, "R9", 1'b0);

    finish_run();
  end
endmodule